// File: doc/BRIEF.md
# Register File with In-Order Write Locking

This block holds the register state of a pipelined RISC execution unit and keeps it coherent while several results are still in flight. When an instruction leaves decode it reserves its destination register through the issue port. That reservation locks the register until the matching result comes back on the retire port. An operand read that names a locked register is held off by back-pressure. Reads of registers that are not locked go ahead, however many writes are pending. The hazard check is a plain comparison against a combined lock mask, so there is no arbitration between readers and writers.

Thirty-one physical registers stand behind sixteen logical ones. A 3-bit mode input on each request selects which physical copy a logical number refers to. Issue, read and retire are all valid/ready ports. A transfer happens on a rising clock edge where both valid and ready are high. A source may hold valid high for as long as ready is low, and drops nothing while it waits. Read results come back on a plain output one cycle after the read is accepted. That output has no back-pressure. Retirement is in issue order. A retire carries only data, because the queue remembers which physical register each pending write targets.

Top module: `regfile_lock`

## Requirements
- R1: After a synchronous active-low reset, no write is pending, `iss_ready` is 1, `wb_ready` is 0, `rsp_valid` is 0, and every physical register reads as zero.
- R2: Logical register r maps to a physical register through the mode. In mode 1, r8..r14 map to 16..22. In modes 2, 3, 4 and 5, r13 and r14 map to 23/24, 25/26, 27/28 and 29/30 respectively. Every other combination, including all of modes 0, 6 and 7, maps r to physical r.
- R3: An accepted issue locks the physical register it targets. While that lock is held, `rd_ready` is 0 for any read whose source operand maps to that register, and such a read returns no response.
- R4: A read whose two sources both map to unlocked registers is accepted at once, even while other writes are pending.
- R5: Several writes to the same register may be pending at once. The register stays locked until the last of them retires, and then holds the value of the last one.
- R6: Each accepted retire writes `wb_data` into the register of the oldest pending issue and releases that issue's lock in the same edge.
- R7: With QDEPTH writes pending, `iss_ready` is 0, and an issue offered in that state is ignored: it locks nothing.
- R8: With no write pending, `wb_ready` is 0, and a retire offered in that state changes no register.
- R9: Logical r15 is never locked, so a read of r15 is never stalled by a pending write to it. A write to r15 still retires in order and updates it.
- R10: The cycle after a read is accepted, `rsp_valid` is 1 and `rsp_data_a`/`rsp_data_b` hold the two source values as they stood after every retire up to and including the previous cycle. In a cycle with no accepted read, `rsp_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request: lock a destination |
| iss_ready | output | 1 | Lock queue has room |
| iss_dst | input | 4 | Logical destination register |
| iss_mode | input | 3 | Mode for the destination mapping |
| rd_valid | input | 1 | Operand read request |
| rd_ready | output | 1 | Neither source is locked |
| rd_mode | input | 3 | Mode for the source mapping |
| rd_src_a | input | 4 | Logical source register A |
| rd_src_b | input | 4 | Logical source register B |
| rsp_valid | output | 1 | Read result valid |
| rsp_data_a | output | DATA_W | Value of source A |
| rsp_data_b | output | DATA_W | Value of source B |
| wb_valid | input | 1 | Result of the oldest pending write |
| wb_ready | output | 1 | At least one write pending |
| wb_data | input | DATA_W | Result value |

## Verification
The bench targets a register with two writes in flight. A design that cleared the lock on the first retire would hand the reader the stale intermediate value. It tests a full queue being offered a fifth issue. A design that accepted the issue, or recorded it anyway, would leave a register locked forever. It also checks that a banked register and its base copy stay separate across modes. A wrong mapping shows up as data leaking between modes. It checks r15 as well: locking r15 would stall a read of it. A random sequence with random retire delays is checked against an in-order model, which catches retires written to the wrong slot and reads that sample before the lock clears.

// File: rtl/regfile_lock_pkg.sv
package regfile_lock_pkg;

  localparam int LOG_W  = 4;
  localparam int PHYS_N = 31;
  localparam int PHYS_W = $clog2(PHYS_N);
  localparam int MODE_W = 3;
  localparam logic [LOG_W-1:0] PC_REG = 4'd15;

  typedef enum logic [MODE_W-1:0] {
    MODE_BASE = 3'd0,
    MODE_FAST = 3'd1,
    MODE_SUPV = 3'd2,
    MODE_INTR = 3'd3,
    MODE_ABRT = 3'd4,
    MODE_UNDF = 3'd5
  } mode_e;

  // Logical-to-physical mapping with banked upper registers per mode.
  function automatic logic [PHYS_W-1:0] map_phys(input logic [LOG_W-1:0] r,
                                                 input logic [MODE_W-1:0] m);
    logic [PHYS_W-1:0] rp;
    rp = PHYS_W'(r);
    if (m == MODE_FAST && r >= 4'd8 && r <= 4'd14)
      return rp + 5'd8;                 // r8..r14 -> 16..22
    if (r == 4'd13 || r == 4'd14) begin
      case (m)
        MODE_SUPV: return rp + 5'd10;   // 23/24
        MODE_INTR: return rp + 5'd12;   // 25/26
        MODE_ABRT: return rp + 5'd14;   // 27/28
        MODE_UNDF: return rp + 5'd16;   // 29/30
        default:   return rp;
      endcase
    end
    return rp;
  endfunction

endpackage

// File: rtl/rfl_lock_queue.sv
module rfl_lock_queue #(
  parameter int DEPTH = 4,
  parameter int NREG  = 31,
  localparam int IW   = $clog2(NREG),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [IW-1:0]   push_idx,
  input  logic            push_lock,
  input  logic            pop,
  output logic            full,
  output logic            empty,
  output logic [IW-1:0]   head_idx,
  output logic [NREG-1:0] lock_mask
);

  logic [NREG-1:0] ent_mask [DEPTH];
  logic [IW-1:0]   ent_idx  [DEPTH];
  logic [DEPTH-1:0] ent_vld;
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   cnt;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign head_idx = ent_idx[rd_ptr];

  always_comb begin
    lock_mask = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ent_vld[i]) lock_mask |= ent_mask[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      ent_vld <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_mask[i] <= '0;
        ent_idx[i]  <= '0;
      end
    end else begin
      if (push) begin
        ent_mask[wr_ptr] <= push_lock ? (NREG'(1) << push_idx) : '0;
        ent_idx[wr_ptr]  <= push_idx;
        ent_vld[wr_ptr]  <= 1'b1;
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) begin
        ent_vld[rd_ptr] <= 1'b0;
        rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

endmodule

// File: rtl/rfl_storage.sv
module rfl_storage #(
  parameter int DATA_W = 32,
  parameter int NREG   = 31,
  localparam int IW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IW-1:0]     ra_idx,
  input  logic [IW-1:0]     rb_idx,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data
);

  localparam logic [IW-1:0] LAST = IW'(NREG - 1);

  logic [DATA_W-1:0] mem [NREG];

  assign ra_data = (ra_idx <= LAST) ? mem[ra_idx] : '0;
  assign rb_data = (rb_idx <= LAST) ? mem[rb_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en && wr_idx <= LAST) begin
      mem[wr_idx] <= wr_data;
    end
  end

endmodule

// File: rtl/regfile_lock.sv
module regfile_lock
  import regfile_lock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [3:0]        iss_dst,
  input  logic [2:0]        iss_mode,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [2:0]        rd_mode,
  input  logic [3:0]        rd_src_a,
  input  logic [3:0]        rd_src_b,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data_a,
  output logic [DATA_W-1:0] rsp_data_b,
  input  logic              wb_valid,
  output logic              wb_ready,
  input  logic [DATA_W-1:0] wb_data
);

  logic [PHYS_W-1:0] pa, pb, pd, head_idx;
  logic [PHYS_N-1:0] lock_mask;
  logic              q_full, q_empty, iss_fire, wb_fire, rd_fire;
  logic [DATA_W-1:0] va, vb;

  assign pa = map_phys(rd_src_a, rd_mode);
  assign pb = map_phys(rd_src_b, rd_mode);
  assign pd = map_phys(iss_dst, iss_mode);

  assign iss_ready = !q_full;
  assign wb_ready  = !q_empty;
  assign rd_ready  = !(lock_mask[pa] || lock_mask[pb]);
  assign iss_fire  = iss_valid && iss_ready;
  assign wb_fire   = wb_valid && wb_ready;
  assign rd_fire   = rd_valid && rd_ready;

  rfl_lock_queue #(.DEPTH(QDEPTH), .NREG(PHYS_N)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (iss_fire),
    .push_idx  (pd),
    .push_lock (iss_dst != PC_REG),
    .pop       (wb_fire),
    .full      (q_full),
    .empty     (q_empty),
    .head_idx  (head_idx),
    .lock_mask (lock_mask)
  );

  rfl_storage #(.DATA_W(DATA_W), .NREG(PHYS_N)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wb_fire),
    .wr_idx  (head_idx),
    .wr_data (wb_data),
    .ra_idx  (pa),
    .rb_idx  (pb),
    .ra_data (va),
    .rb_data (vb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data_a <= '0;
      rsp_data_b <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        rsp_data_a <= va;
        rsp_data_b <= vb;
      end
    end
  end

endmodule

// File: rtl/rfl_checker.sv
module rfl_checker #(
  parameter int QDEPTH = 4,
  localparam int CW = $clog2(QDEPTH + 1) + 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       iss_valid,
  input logic       iss_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [3:0] rd_src_a,
  input logic [3:0] rd_src_b,
  input logic       rsp_valid,
  input logic       wb_valid,
  input logic       wb_ready
);

  logic [CW-1:0] pend;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else pend <= pend + CW'(iss_valid && iss_ready) - CW'(wb_valid && wb_ready);
  end

  // R1
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);

  assert_issue_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_ready == (pend < CW'(QDEPTH)));

  assert_retire_only_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ready == (pend != '0));

  assert_pc_read_never_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_src_a == 4'd15 && rd_src_b == 4'd15) |-> rd_ready);

  assert_rsp_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);

  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |=> !rsp_valid);

endmodule

bind regfile_lock rfl_checker #(.QDEPTH(QDEPTH)) u_chk (.*);

// File: tb/tb_regfile_lock.sv
module tb_regfile_lock;

  localparam int CLK_PERIOD = 10;
  localparam int QD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0, rd_valid = 1'b0, wb_valid = 1'b0;
  logic [3:0]  iss_dst = '0, rd_src_a = '0, rd_src_b = '0;
  logic [2:0]  iss_mode = '0, rd_mode = '0;
  logic [31:0] wb_data = '0;
  logic        iss_ready, rd_ready, wb_ready, rsp_valid;
  logic [31:0] rsp_data_a, rsp_data_b;

  int checks = 0, errors = 0;
  logic [31:0] refm [31];
  int q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_lock #(.DATA_W(32), .QDEPTH(QD)) dut (.*);

  function automatic int bmap(input int r, input int m);
    if (m == 1 && r >= 8 && r <= 14) return 16 + (r - 8);
    if (r == 13 || r == 14) begin
      if (m >= 2 && m <= 5) return 23 + 2 * (m - 2) + (r - 13);
    end
    return r;
  endfunction

  function automatic bit locked(input int p);
    if (p == 15) return 1'b0;
    foreach (q[i]) if (q[i] == p) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic op_issue(input int d, input int m);
    bit exp_rdy;
    @(negedge clk);
    iss_valid = 1'b1; iss_dst = 4'(d); iss_mode = 3'(m);
    exp_rdy = (q.size() < QD);
    #1 chk(iss_ready == exp_rdy, "R7 iss_ready", 32'(iss_ready), 32'(exp_rdy));
    @(posedge clk);
    #1 iss_valid = 1'b0;
    if (exp_rdy) q.push_back(bmap(d, m));
  endtask

  task automatic op_retire(input logic [31:0] v);
    bit exp_rdy;
    @(negedge clk);
    wb_valid = 1'b1; wb_data = v;
    exp_rdy = (q.size() != 0);
    #1 chk(wb_ready == exp_rdy, "R8 wb_ready", 32'(wb_ready), 32'(exp_rdy));
    @(posedge clk);
    #1 wb_valid = 1'b0;
    if (exp_rdy) refm[q.pop_front()] = v;
  endtask

  task automatic op_read(input int a, input int b, input int m, input string req);
    bit exp_rdy;
    int pa, pb;
    pa = bmap(a, m); pb = bmap(b, m);
    @(negedge clk);
    rd_valid = 1'b1; rd_src_a = 4'(a); rd_src_b = 4'(b); rd_mode = 3'(m);
    exp_rdy = !(locked(pa) || locked(pb));
    #1 chk(rd_ready == exp_rdy, {req, " R3/R4 rd_ready"}, 32'(rd_ready), 32'(exp_rdy));
    @(posedge clk);
    #1 rd_valid = 1'b0;
    if (exp_rdy) begin
      chk(rsp_valid == 1'b1, {req, " R10 rsp_valid"}, 32'(rsp_valid), 1);
      chk(rsp_data_a == refm[pa], {req, " R10 data a"}, rsp_data_a, refm[pa]);
      chk(rsp_data_b == refm[pb], {req, " R10 data b"}, rsp_data_b, refm[pb]);
    end else begin
      chk(rsp_valid == 1'b0, {req, " R3 no rsp"}, 32'(rsp_valid), 0);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(iss_ready == 1'b1, "R1 iss_ready", 32'(iss_ready), 1);
    chk(wb_ready == 1'b0, "R1 wb_ready", 32'(wb_ready), 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    op_read(0, 14, 0, "R1");
    op_read(13, 14, 1, "R1");
  endtask

  task automatic t_basic_lock();
    op_issue(3, 0);
    op_read(3, 4, 0, "R3");
    op_read(4, 5, 0, "R4");
    op_retire(32'hA5A5_0003);
    op_read(3, 3, 0, "R6");
  endtask

  task automatic t_banking();
    op_issue(13, 2); op_retire(32'h0000_2013);
    op_read(13, 13, 0, "R2");
    op_read(13, 14, 2, "R2");
    op_issue(8, 1); op_retire(32'h0000_1008);
    op_read(8, 8, 0, "R2");
    op_read(8, 9, 1, "R2");
    op_issue(14, 5); op_retire(32'h0000_5014);
    op_read(14, 13, 5, "R2");
    op_read(14, 13, 7, "R2");
    op_read(14, 13, 3, "R2");
  endtask

  task automatic t_same_reg();
    op_issue(5, 0); op_issue(5, 0);
    op_retire(32'h1111_0005);
    op_read(5, 0, 0, "R5");
    op_retire(32'h2222_0005);
    op_read(5, 5, 0, "R5");
    chk(refm[5] == 32'h2222_0005, "R5 model", refm[5], 32'h2222_0005);
  endtask

  task automatic t_order();
    op_issue(1, 0); op_issue(9, 1); op_issue(2, 0);
    op_read(1, 2, 0, "R6");
    op_retire(32'hB001); op_retire(32'hB009); op_retire(32'hB002);
    op_read(1, 2, 0, "R6");
    op_read(9, 9, 1, "R6");
    op_read(9, 9, 0, "R6");
  endtask

  task automatic t_full_empty();
    op_issue(6, 0); op_issue(7, 0); op_issue(11, 0); op_issue(12, 0);
    op_issue(10, 0);  // offered while full: must be ignored (R7)
    op_read(10, 10, 0, "R7");
    op_retire(32'hC006); op_retire(32'hC007); op_retire(32'hC011); op_retire(32'hC012);
    op_retire(32'hDEAD_BEEF);  // offered while empty: no effect (R8)
    op_read(6, 12, 0, "R8");
    op_read(10, 7, 0, "R8");
  endtask

  task automatic t_pc();
    op_issue(15, 3);
    op_read(15, 15, 3, "R9");
    op_retire(32'hF00D_0015);
    op_read(15, 15, 0, "R9");
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++) begin
      int sel;
      sel = $urandom_range(0, 2);
      if (sel == 0) op_issue($urandom_range(0, 15), $urandom_range(0, 7));
      else if (sel == 1) op_retire($urandom);
      else op_read($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 7), "R10 random");
    end
    while (q.size() != 0) op_retire($urandom);
    for (int r = 0; r < 16; r++) op_read(r, 15 - r, r % 8, "R6 drain");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    foreach (refm[i]) refm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic_lock();
    t_banking();
    t_same_reg();
    t_order();
    t_full_empty();
    t_pc();
    t_random();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule